// File: doc/BRIEF.md
# Display Cursor Register Bank with Update Lock

This block holds every control value a hardware display cursor engine needs: on/off, pixel mode, double-size magnification, an inverse-transparent clamp, screen position, hotspot offset, size, two palette colours and a 40-bit base address for the cursor image. Software programs these through a single-cycle register write port and reads them back through a combinational read port. Each write lands in a pending copy. The cursor engine only ever sees a separate live copy, which changes at well-defined commit points.

With the update lock clear, a write to any control register is committed to the live copy two clock edges later, together with a one-cycle commit pulse. With the lock set, changes build up in the pending copy and are all applied together when the lock is released. The base address has its own rule. The upper byte is written first and has no effect by itself. The write of the lower word moves both halves into the live address at once, and raises an address-valid pulse. If the lock is set, that transfer waits for the unlock.

Top module: `cursor_regbank`

## Requirements
- R1: After reset, all live outputs are zero except that cur_width and cur_height read 1 and cur_color2 reads 24'hFFFFFF (the reset mode is monochrome). The lock is clear, both pulses are low, and every register reads back zero.
- R2: A write is visible on bus_rdata in the next cycle, for the register selected by bus_addr. Reads return pending values. The address-low register reads back with bits 11:0 as zero. An unmapped index reads zero.
- R3: With the lock clear, a write to a control register (indices 0 to 5) sampled at edge k updates the live outputs after edge k+1. cur_commit is high for exactly that one cycle.
- R4: While the lock (index 8, bit 0) is set, writes to control registers and to the address registers leave every live output unchanged. Neither cur_commit nor cur_addr_valid is raised.
- R5: Writing 0 to the lock while it is set commits all pending control values together, with the R3 timing and a single cur_commit pulse. The lock then reads 0.
- R6: With the lock clear, a write to address-high (index 6, bits 7:0) alone changes neither cur_base_addr nor cur_addr_valid. A write to address-low (index 7, bits 31:12) sets cur_base_addr to {high, low[31:12], 12'h000}, with the R3 timing and a one-cycle cur_addr_valid pulse.
- R7: An address-low write made while the lock is set is applied at the unlock, in the same cycle as cur_commit. It uses the address-high value that is pending at that time. An unlock with no deferred address-low write raises no cur_addr_valid.
- R8: Mode (index 0, bits 2:1) encodes 0 monochrome, 1 colour with 1-bit AND mask, 2 premultiplied alpha and 3 non-premultiplied alpha. In live mode 0, cur_color1 is 24'h000000 and cur_color2 is 24'hFFFFFF. In the other modes the colour outputs carry the programmed {red[23:16], green[15:8], blue[7:0]}.
- R9: The size register (index 3) stores width minus one in bits 7:0 and height minus one in bits 15:8. cur_width and cur_height output the stored value plus one, so a stored 0 gives 1 and a stored 127 gives 128.
- R10: The field layout is as follows. Index 0: enable bit 0, magnify bit 3, clamp bit 4. Index 1: X in bits 15:0 and Y in bits 31:16. Index 2: hotspot X in bits 7:0 and hotspot Y in bits 15:8. Indices 4 and 5: colour 1 and colour 2.
- R11: Control writes on consecutive cycles with the lock clear are each committed in order. The live value steps through both, with one cur_commit pulse per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Register index for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Pending value of the register at bus_addr |
| cur_en | output | 1 | Live cursor enable |
| cur_mode | output | 2 | Live pixel mode |
| cur_mag2x | output | 1 | Live double-size magnification |
| cur_inv_clamp | output | 1 | Live inverse-transparent clamp |
| cur_x | output | COORD_W | Live X position |
| cur_y | output | COORD_W | Live Y position |
| cur_hot_x | output | HOT_W | Live hotspot X |
| cur_hot_y | output | HOT_W | Live hotspot Y |
| cur_width | output | SIZE_W+1 | Live width in pixels |
| cur_height | output | SIZE_W+1 | Live height in pixels |
| cur_color1 | output | 24 | Live colour 1 {R,G,B} |
| cur_color2 | output | 24 | Live colour 2 {R,G,B} |
| cur_base_addr | output | 40 | Live 4 KB-aligned image base address |
| cur_addr_valid | output | 1 | One-cycle pulse when the live address changes |
| cur_commit | output | 1 | One-cycle pulse when the live control values change |

## Verification
Two overlaps are provoked. The first is a control commit landing in the same cycle as a new pending write. Two control writes are issued back to back, and the live X position must show the first value for one cycle and then the second, with a commit pulse in each cycle. The second is the unlock that must raise cur_commit and cur_addr_valid in the same cycle. An address-low write is deferred under the lock, and at the unlock both pulses and both the new position and the new address are checked in one sample.

// File: rtl/cursor_regbank_pkg.sv
// Package: register indices, mode codes, colour type and address split
// shared by the cursor register bank modules.
package cursor_regbank_pkg;

    localparam int IDX_W      = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 40;
    localparam int ADDR_HI_W  = 8;
    localparam int ALIGN_BITS = 12;
    localparam int ADDR_LO_W  = ADDR_W - ADDR_HI_W - ALIGN_BITS;

    typedef enum logic [IDX_W-1:0] {
        RG_CTRL    = 4'd0,
        RG_POS     = 4'd1,
        RG_HOT     = 4'd2,
        RG_SIZE    = 4'd3,
        RG_COL1    = 4'd4,
        RG_COL2    = 4'd5,
        RG_ADDR_HI = 4'd6,
        RG_ADDR_LO = 4'd7,
        RG_LOCK    = 4'd8
    } reg_idx_e;

    typedef enum logic [1:0] {
        MODE_MONO     = 2'd0,
        MODE_AND_MASK = 2'd1,
        MODE_PREMUL   = 2'd2,
        MODE_STRAIGHT = 2'd3
    } cur_mode_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    localparam rgb_t RGB_BLACK = 24'h000000;
    localparam rgb_t RGB_WHITE = 24'hFFFFFF;

endpackage

// File: rtl/cur_pending_regs.sv
// Pending register file. It decodes bus writes into the pending copies,
// drives the combinational read-back mux, and flags the events that the
// commit controller acts on. Assumes one write per cycle and that the
// field widths fit their slots (COORD_W <= 16, HOT_W <= 8, SIZE_W <= 8).
module cur_pending_regs
    import cursor_regbank_pkg::*;
#(
    parameter int COORD_W = 13,
    parameter int HOT_W   = 6,
    parameter int SIZE_W  = 7,
    localparam int FLD_W  = 5 + 2*COORD_W + 2*HOT_W + 2*SIZE_W + 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [IDX_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [FLD_W-1:0]     pend_fields,
    output logic [ADDR_HI_W-1:0] pend_addr_hi,
    output logic [ADDR_LO_W-1:0] pend_addr_lo,
    output logic                 lock_q,
    output logic                 fld_wr,
    output logic                 lo_wr,
    output logic                 unlock_evt
);

    logic               p_en, p_mag, p_clamp;
    logic [1:0]         p_mode;
    logic [COORD_W-1:0] p_x, p_y;
    logic [HOT_W-1:0]   p_hx, p_hy;
    logic [SIZE_W-1:0]  p_w, p_h;
    rgb_t               p_col1, p_col2;

    // Event decode: control-register write, address-low write, lock release.
    always_comb begin
        fld_wr     = bus_wr && (bus_addr <= RG_COL2);
        lo_wr      = bus_wr && (bus_addr == RG_ADDR_LO);
        unlock_evt = bus_wr && (bus_addr == RG_LOCK) && !bus_wdata[0] && lock_q;
    end

    // Pending storage: capture the addressed register's fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_en <= 1'b0; p_mag <= 1'b0; p_clamp <= 1'b0; p_mode <= '0;
            p_x <= '0; p_y <= '0; p_hx <= '0; p_hy <= '0;
            p_w <= '0; p_h <= '0; p_col1 <= '0; p_col2 <= '0;
            pend_addr_hi <= '0; pend_addr_lo <= '0; lock_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                RG_CTRL: begin
                    p_en    <= bus_wdata[0];
                    p_mode  <= bus_wdata[2:1];
                    p_mag   <= bus_wdata[3];
                    p_clamp <= bus_wdata[4];
                end
                RG_POS: begin
                    p_x <= bus_wdata[COORD_W-1:0];
                    p_y <= bus_wdata[16 +: COORD_W];
                end
                RG_HOT: begin
                    p_hx <= bus_wdata[HOT_W-1:0];
                    p_hy <= bus_wdata[8 +: HOT_W];
                end
                RG_SIZE: begin
                    p_w <= bus_wdata[SIZE_W-1:0];
                    p_h <= bus_wdata[8 +: SIZE_W];
                end
                RG_COL1:    p_col1       <= bus_wdata[23:0];
                RG_COL2:    p_col2       <= bus_wdata[23:0];
                RG_ADDR_HI: pend_addr_hi <= bus_wdata[ADDR_HI_W-1:0];
                RG_ADDR_LO: pend_addr_lo <= bus_wdata[DATA_W-1:ALIGN_BITS];
                RG_LOCK:    lock_q       <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Read-back mux over the pending copies.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RG_CTRL: begin
                bus_rdata[0]   = p_en;
                bus_rdata[2:1] = p_mode;
                bus_rdata[3]   = p_mag;
                bus_rdata[4]   = p_clamp;
            end
            RG_POS: begin
                bus_rdata[COORD_W-1:0]  = p_x;
                bus_rdata[16 +: COORD_W] = p_y;
            end
            RG_HOT: begin
                bus_rdata[HOT_W-1:0] = p_hx;
                bus_rdata[8 +: HOT_W] = p_hy;
            end
            RG_SIZE: begin
                bus_rdata[SIZE_W-1:0] = p_w;
                bus_rdata[8 +: SIZE_W] = p_h;
            end
            RG_COL1:    bus_rdata[23:0] = p_col1;
            RG_COL2:    bus_rdata[23:0] = p_col2;
            RG_ADDR_HI: bus_rdata[ADDR_HI_W-1:0] = pend_addr_hi;
            RG_ADDR_LO: bus_rdata[DATA_W-1:ALIGN_BITS] = pend_addr_lo;
            RG_LOCK:    bus_rdata[0] = lock_q;
            default: ;
        endcase
    end

    // Pack the control fields for the live stage.
    assign pend_fields = {p_en, p_mode, p_mag, p_clamp, p_x, p_y,
                          p_hx, p_hy, p_w, p_h, p_col1, p_col2};

    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_evt |=> !lock_q); // R5

endmodule

// File: rtl/cur_commit_ctrl.sv
// Commit controller. It turns the write events into registered commit
// requests for the control fields and the address, and tracks an
// address-low write that is held back by the lock. Assumes the events
// are mutually exclusive (one bus write per cycle).
module cur_commit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fld_wr,
    input  logic lo_wr,
    input  logic unlock_evt,
    input  logic lock_q,
    output logic fld_req,
    output logic addr_req
);

    logic defer_q;

    // Request registers and the deferred-address flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_req  <= 1'b0;
            addr_req <= 1'b0;
            defer_q  <= 1'b0;
        end else begin
            fld_req  <= (fld_wr && !lock_q) || unlock_evt;
            addr_req <= (lo_wr && !lock_q) || (unlock_evt && defer_q);
            if (unlock_evt)
                defer_q <= 1'b0;
            else if (lo_wr && lock_q)
                defer_q <= 1'b1;
        end
    end

    AST_DEFER_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        defer_q |-> lock_q); // R7

endmodule

// File: rtl/cur_live_regs.sv
// Live register stage. It copies the pending control fields or the
// pending address into the live copies on a commit request, raises the
// matching one-cycle pulses, and forms the engine-facing outputs
// (size plus one, monochrome colour override, aligned address).
module cur_live_regs
    import cursor_regbank_pkg::*;
#(
    parameter int COORD_W = 13,
    parameter int HOT_W   = 6,
    parameter int SIZE_W  = 7,
    localparam int FLD_W  = 5 + 2*COORD_W + 2*HOT_W + 2*SIZE_W + 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fld_req,
    input  logic                 addr_req,
    input  logic [FLD_W-1:0]     pend_fields,
    input  logic [ADDR_HI_W-1:0] pend_addr_hi,
    input  logic [ADDR_LO_W-1:0] pend_addr_lo,
    output logic                 cur_en,
    output logic [1:0]           cur_mode,
    output logic                 cur_mag2x,
    output logic                 cur_inv_clamp,
    output logic [COORD_W-1:0]   cur_x,
    output logic [COORD_W-1:0]   cur_y,
    output logic [HOT_W-1:0]     cur_hot_x,
    output logic [HOT_W-1:0]     cur_hot_y,
    output logic [SIZE_W:0]      cur_width,
    output logic [SIZE_W:0]      cur_height,
    output logic [23:0]          cur_color1,
    output logic [23:0]          cur_color2,
    output logic [ADDR_W-1:0]    cur_base_addr,
    output logic                 cur_addr_valid,
    output logic                 cur_commit
);

    localparam int LIVE_ADDR_W = ADDR_HI_W + ADDR_LO_W;

    logic [FLD_W-1:0]       live_q;
    logic [LIVE_ADDR_W-1:0] live_addr_q;
    logic [SIZE_W-1:0]      l_w, l_h;
    rgb_t                   l_col1, l_col2;

    // Live copies and their pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q         <= '0;
            live_addr_q    <= '0;
            cur_commit     <= 1'b0;
            cur_addr_valid <= 1'b0;
        end else begin
            cur_commit     <= fld_req;
            cur_addr_valid <= addr_req;
            if (fld_req)  live_q      <= pend_fields;
            if (addr_req) live_addr_q <= {pend_addr_hi, pend_addr_lo};
        end
    end

    // Unpack the live fields.
    assign {cur_en, cur_mode, cur_mag2x, cur_inv_clamp, cur_x, cur_y,
            cur_hot_x, cur_hot_y, l_w, l_h, l_col1, l_col2} = live_q;

    // Engine-facing derived values.
    always_comb begin
        cur_width  = {1'b0, l_w} + 1'b1;
        cur_height = {1'b0, l_h} + 1'b1;
        if (cur_mode == MODE_MONO) begin
            cur_color1 = RGB_BLACK;
            cur_color2 = RGB_WHITE;
        end else begin
            cur_color1 = l_col1;
            cur_color2 = l_col2;
        end
        cur_base_addr = {live_addr_q, {ALIGN_BITS{1'b0}}};
    end

    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_req |=> $stable(cur_base_addr)); // R6

endmodule

// File: rtl/cursor_regbank.sv
// Top of the cursor register bank: pending file, commit controller and
// live stage. Writes reach the cursor engine only through commits.
module cursor_regbank
    import cursor_regbank_pkg::*;
#(
    parameter int COORD_W = 13,
    parameter int HOT_W   = 6,
    parameter int SIZE_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               cur_en,
    output logic [1:0]         cur_mode,
    output logic               cur_mag2x,
    output logic               cur_inv_clamp,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output logic [HOT_W-1:0]   cur_hot_x,
    output logic [HOT_W-1:0]   cur_hot_y,
    output logic [SIZE_W:0]    cur_width,
    output logic [SIZE_W:0]    cur_height,
    output logic [23:0]        cur_color1,
    output logic [23:0]        cur_color2,
    output logic [39:0]        cur_base_addr,
    output logic               cur_addr_valid,
    output logic               cur_commit
);

    localparam int FLD_W = 5 + 2*COORD_W + 2*HOT_W + 2*SIZE_W + 48;

    logic [FLD_W-1:0]     pend_fields;
    logic [ADDR_HI_W-1:0] pend_addr_hi;
    logic [ADDR_LO_W-1:0] pend_addr_lo;
    logic                 lock_q, fld_wr, lo_wr, unlock_evt;
    logic                 fld_req, addr_req;

    cur_pending_regs #(.COORD_W(COORD_W), .HOT_W(HOT_W), .SIZE_W(SIZE_W)) u_pend (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .pend_fields, .pend_addr_hi, .pend_addr_lo,
        .lock_q, .fld_wr, .lo_wr, .unlock_evt
    );

    cur_commit_ctrl u_ctrl (
        .clk, .rst_n, .fld_wr, .lo_wr, .unlock_evt, .lock_q,
        .fld_req, .addr_req
    );

    cur_live_regs #(.COORD_W(COORD_W), .HOT_W(HOT_W), .SIZE_W(SIZE_W)) u_live (
        .clk, .rst_n, .fld_req, .addr_req,
        .pend_fields, .pend_addr_hi, .pend_addr_lo,
        .cur_en, .cur_mode, .cur_mag2x, .cur_inv_clamp,
        .cur_x, .cur_y, .cur_hot_x, .cur_hot_y,
        .cur_width, .cur_height, .cur_color1, .cur_color2,
        .cur_base_addr, .cur_addr_valid, .cur_commit
    );

    AST_WRITE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_wr && !lock_q) |=> ##1 cur_commit); // R3

    AST_LOCK_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !unlock_evt) |=> ##1 !cur_commit); // R4

    AST_LO_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && lock_q) |=> ##1 !cur_addr_valid); // R7

    AST_UNLOCK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_evt |=> ##1 cur_commit); // R5

endmodule

// File: tb/cursor_regbank_tb_top.sv
`timescale 1ns/1ps
module cursor_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        cur_en, cur_mag2x, cur_inv_clamp;
    logic [1:0]  cur_mode;
    logic [12:0] cur_x, cur_y;
    logic [5:0]  cur_hot_x, cur_hot_y;
    logic [7:0]  cur_width, cur_height;
    logic [23:0] cur_color1, cur_color2;
    logic [39:0] cur_base_addr;
    logic        cur_addr_valid, cur_commit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cursor_regbank dut_i (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .cur_en, .cur_mode, .cur_mag2x, .cur_inv_clamp,
        .cur_x, .cur_y, .cur_hot_x, .cur_hot_y,
        .cur_width, .cur_height, .cur_color1, .cur_color2,
        .cur_base_addr, .cur_addr_valid, .cur_commit
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write is sampled at the next posedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 en", cur_en, 0);
        chk("R1 mode", cur_mode, 0);
        chk("R1 x", cur_x, 0);
        chk("R1 width", cur_width, 1);
        chk("R1 height", cur_height, 1);
        chk("R1 color1", cur_color1, 24'h000000);
        chk("R1 color2", cur_color2, 24'hFFFFFF);
        chk("R1 base", cur_base_addr, 0);
        chk("R1 pulses", {cur_commit, cur_addr_valid}, 0);
        rd(4'd0, d); chk("R1 read ctrl", d, 0);
        rd(4'd8, d); chk("R1 read lock", d, 0);
        @(negedge clk);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr(4'd1, 32'h0456_0123);
        rd(4'd1, d); chk("R2 R10 read pos", d, 32'h0456_0123);
        @(negedge clk);
        wr(4'd7, 32'h1234_5ABC);
        rd(4'd7, d); chk("R2 read addr lo", d, 32'h1234_5000);
        rd(4'd9, d); chk("R2 unmapped", d, 0);
        @(negedge clk);
        chk("R10 live x", cur_x, 13'h123);
        chk("R10 live y", cur_y, 13'h456);
        chk("R6 base after lo", cur_base_addr, 40'h00_1234_5000);
        @(negedge clk);
    endtask

    task automatic t_unlocked_commit;
        wr(4'd0, 32'h1D);
        chk("R3 no early commit", cur_commit, 0);
        chk("R3 no early en", cur_en, 0);
        @(negedge clk);
        chk("R3 commit pulse", cur_commit, 1);
        chk("R3 R10 ctrl fields", {cur_en, cur_mode, cur_mag2x, cur_inv_clamp}, 5'b1_10_1_1);
        @(negedge clk);
        chk("R3 pulse one cycle", cur_commit, 0);
    endtask

    task automatic t_colours;
        logic [31:0] d;
        wr(4'd4, 32'h0011_2233);
        @(negedge clk);
        chk("R8 colour1 premul", cur_color1, 24'h112233);
        chk("R8 colour2 premul", cur_color2, 24'h000000);
        wr(4'd0, 32'h01);
        @(negedge clk);
        chk("R8 mono mode", cur_mode, 0);
        chk("R8 mono colour1", cur_color1, 24'h000000);
        chk("R8 mono colour2", cur_color2, 24'hFFFFFF);
        rd(4'd4, d); chk("R2 colour1 pending kept", d, 32'h0011_2233);
        @(negedge clk);
    endtask

    task automatic t_size;
        wr(4'd3, 32'h0000_7F00);
        @(negedge clk);
        chk("R9 width min", cur_width, 1);
        chk("R9 height max", cur_height, 128);
        @(negedge clk);
    endtask

    task automatic t_addr;
        wr(4'd6, 32'h01);
        for (int i = 0; i < 3; i++) begin
            chk("R6 hi alone no pulse", cur_addr_valid, 0);
            chk("R6 hi alone no change", cur_base_addr, 40'h00_1234_5000);
            @(negedge clk);
        end
        wr(4'd7, 32'h0001_0000);
        chk("R6 valid not early", cur_addr_valid, 0);
        @(negedge clk);
        chk("R6 valid pulse", cur_addr_valid, 1);
        chk("R6 base", cur_base_addr, 40'h01_0001_0000);
        @(negedge clk);
        chk("R6 valid one cycle", cur_addr_valid, 0);
    endtask

    task automatic t_lock;
        logic [31:0] d;
        wr(4'd8, 32'h1);
        rd(4'd8, d); chk("R4 lock reads 1", d, 1);
        wr(4'd1, 32'h0006_0005);
        wr(4'd7, 32'hAAAA_A123);
        wr(4'd6, 32'h3C);
        for (int i = 0; i < 3; i++) begin
            chk("R4 no commit", cur_commit, 0);
            chk("R4 no addr valid", cur_addr_valid, 0);
            chk("R4 x held", cur_x, 13'h123);
            chk("R4 base held", cur_base_addr, 40'h01_0001_0000);
            @(negedge clk);
        end
        wr(4'd8, 32'h0);
        chk("R5 not early", cur_commit, 0);
        @(negedge clk);
        chk("R5 commit", cur_commit, 1);
        chk("R7 addr valid with commit", cur_addr_valid, 1);
        chk("R5 x", cur_x, 5);
        chk("R5 y", cur_y, 6);
        chk("R7 base", cur_base_addr, 40'h3C_AAAA_A000);
        rd(4'd8, d); chk("R5 lock reads 0", d, 0);
        @(negedge clk);
        chk("R5 single pulse", {cur_commit, cur_addr_valid}, 0);
    endtask

    task automatic t_unlock_no_addr;
        wr(4'd8, 32'h1);
        wr(4'd0, 32'h07);
        @(negedge clk);
        chk("R4 mode held", cur_mode, 0);
        wr(4'd8, 32'h0);
        @(negedge clk);
        chk("R5 commit", cur_commit, 1);
        chk("R7 no addr valid", cur_addr_valid, 0);
        chk("R8 mode straight", {cur_en, cur_mode}, 3'b1_11);
        @(negedge clk);
    endtask

    task automatic t_b2b;
        wr(4'd1, 32'h0020_0010);
        wr(4'd1, 32'h0040_0030);
        chk("R11 first commit", cur_commit, 1);
        chk("R11 first x", cur_x, 13'h10);
        @(negedge clk);
        chk("R11 second commit", cur_commit, 1);
        chk("R11 second x", cur_x, 13'h30);
        chk("R11 second y", cur_y, 13'h40);
        @(negedge clk);
        chk("R11 pulses end", cur_commit, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_unlocked_commit();
        t_colours();
        t_size();
        t_addr();
        t_lock();
        t_unlock_no_addr();
        t_b2b();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule